// File: doc/BRIEF.md
# Task-Owned Hardware Repeat Controller

This block gives a multitasking processor a zero-overhead loop. A repeat command carries the program counter of the command itself, a block length and a pass count. The controller records which hardware task issued it and where the block begins and ends. From then on it watches only that task's executing program counter. Each time the task reaches the last instruction of the block, the controller asks the fetch stage to jump back to the first instruction, until the requested number of passes has been made.

Only one repeat is held across all tasks. A later command from any task replaces it. A cancel input drops it at once. If the owning task is sent elsewhere by a task-level jump, the repeat stays armed; the way to clear it is to issue a one-instruction, one-pass repeat.

The controller is a three-state machine:
- `ST_IDLE`: no repeat is held.
- `ST_RUN`: at least two passes remain, so reaching the block end jumps back.
- `ST_FINAL`: the current pass is the last one, so reaching the block end only retires the repeat.

The transitions are:
- *arm-run*: a command with an effective count above one leads to `ST_RUN`.
- *arm-final*: a command with an effective count of one leads to `ST_FINAL`.
- *loop*: an end hit in `ST_RUN` with more than two passes left stays in `ST_RUN`.
- *to-last*: an end hit in `ST_RUN` with exactly two passes left leads to `ST_FINAL`.
- *retire*: an end hit in `ST_FINAL` leads to `ST_IDLE`.
- *drop*: cancel, from any state, leads to `ST_IDLE`.

A command is accepted in any state and overrides the current transition.

Top module: `task_rpt_ctrl`

## Requirements
- R1: A jump-back is requested only for an executed instruction whose task number equals the task that issued the active repeat. Instructions from other tasks at the same PC produce no jump-back and do not consume a pass.
- R2: A command sets the block start to cmd_pc+1 and the block end to cmd_pc+cmd_len. With an effective count N, the first N-1 owner executions of the block end each request a jump with jump_target equal to the block start, in the same cycle. The N-th such execution requests no jump.
- R3: A cmd_count of 0 acts as 1 and a cmd_len of 0 acts as 1. A repeat of one instruction for one pass never produces a jump-back.
- R4: A command replaces any repeat in progress, whichever task owns it. No jump-back is requested in a cycle where cmd_valid is high. The previous owner is then ignored.
- R5: When the owner's PC moves outside the block (a task redirect), the repeat is not cleared. It jumps back on the next owner execution of the block end.
- R6: In the cycle cancel is high, active is low and no jump is requested. The repeat is cleared, and cancel wins over a command in the same cycle.
- R7: Synchronous reset clears the repeat. After reset, active is low and no jump is requested.
- R8: With exec_valid low, no jump is requested and no pass is consumed.
- R9: The block end is computed modulo 2^PCW, so a block may wrap past the top of the address space.
- R10: active is high from the cycle after an accepted command until the cycle of the final end execution, inclusive. It is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Repeat command issued this cycle |
| cmd_task | input | TW | Task that issued the command |
| cmd_pc | input | PCW | PC of the repeat command |
| cmd_len | input | PCW | Block length in instructions (0 treated as 1) |
| cmd_count | input | CW | Number of passes (0 treated as 1) |
| cancel | input | 1 | Drop the active repeat in this cycle |
| exec_valid | input | 1 | An instruction executes this cycle |
| exec_task | input | TW | Task of the executing instruction |
| exec_pc | input | PCW | PC of the executing instruction |
| jump_req | output | 1 | Force the owner task back to the block start |
| jump_target | output | PCW | Block start PC |
| active | output | 1 | A repeat is held |

## Verification
The assertions watch every cycle for the following:
- a jump-back that does not belong to the owner's end-of-block execution;
- a jump in the last-pass state;
- any jump while idle or with exec_valid low;
- a cancel that fails to clear;
- a command that fails to arm;
- reset not returning the machine to idle.

Only the bench's scenarios show the rest:
- that exactly N-1 jumps happen for count N;
- that a new command really displaces an older owner;
- that a redirected owner keeps its loop;
- that a block wrapping past the address top still closes.

// File: rtl/rptc_pkg.sv
package rptc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FINAL = 2'd2
    } rpt_state_e;
endpackage

// File: rtl/rptc_span.sv
// Holds owner task and block boundaries of the current repeat.
module rptc_span #(
    parameter int TW  = 2,
    parameter int PCW = 16
) (
    input  logic           clk,
    input  logic           load,
    input  logic [TW-1:0]  cmd_task,
    input  logic [PCW-1:0] cmd_pc,
    input  logic [PCW-1:0] cmd_len,
    output logic [TW-1:0]  owner_q,
    output logic [PCW-1:0] start_q,
    output logic [PCW-1:0] end_q
);
    logic [PCW-1:0] eff_len;

    always_comb begin
        eff_len = (cmd_len == '0) ? PCW'(1) : cmd_len;
    end

    always_ff @(posedge clk) begin
        if (load) begin
            owner_q <= cmd_task;
            start_q <= cmd_pc + PCW'(1);
            end_q   <= cmd_pc + eff_len;
        end
    end
endmodule

// File: rtl/rptc_match.sv
// Detects the owner task executing the block's last instruction.
module rptc_match #(
    parameter int TW  = 2,
    parameter int PCW = 16
) (
    input  logic           exec_valid,
    input  logic [TW-1:0]  exec_task,
    input  logic [PCW-1:0] exec_pc,
    input  logic [TW-1:0]  owner_q,
    input  logic [PCW-1:0] end_q,
    output logic           end_hit
);
    logic task_eq;
    logic pc_eq;

    always_comb begin
        task_eq = (exec_task == owner_q);
        pc_eq   = (exec_pc == end_q);
        end_hit = exec_valid && task_eq && pc_eq;
    end
endmodule

// File: rtl/rptc_passes.sv
// Remaining-pass counter.
module rptc_passes #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          dec,
    input  logic [CW-1:0] cmd_count,
    output logic          multi_cmd,
    output logic          two_left
);
    logic [CW-1:0] rem_q;
    logic [CW-1:0] eff_cnt;

    always_comb begin
        eff_cnt   = (cmd_count == '0) ? CW'(1) : cmd_count;
        multi_cmd = (eff_cnt > CW'(1));
        two_left  = (rem_q == CW'(2));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= eff_cnt;
        end else if (dec) begin
            rem_q <= rem_q - CW'(1);
        end
    end
endmodule

// File: rtl/task_rpt_ctrl.sv
module task_rpt_ctrl #(
    parameter int TASKS = 4,
    parameter int PCW   = 16,
    parameter int CW    = 8,
    localparam int TW   = (TASKS > 1) ? $clog2(TASKS) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cmd_valid,
    input  logic [TW-1:0]  cmd_task,
    input  logic [PCW-1:0] cmd_pc,
    input  logic [PCW-1:0] cmd_len,
    input  logic [CW-1:0]  cmd_count,
    input  logic           cancel,
    input  logic           exec_valid,
    input  logic [TW-1:0]  exec_task,
    input  logic [PCW-1:0] exec_pc,
    output logic           jump_req,
    output logic [PCW-1:0] jump_target,
    output logic           active
);
    import rptc_pkg::*;

    rpt_state_e     st, st_nxt;
    logic           load;
    logic           dec;
    logic           end_hit;
    logic           multi_cmd;
    logic           two_left;
    logic [TW-1:0]  owner_q;
    logic [PCW-1:0] start_q;
    logic [PCW-1:0] end_q;

    rptc_span #(.TW(TW), .PCW(PCW)) u_span (
        .clk      (clk),
        .load     (load),
        .cmd_task (cmd_task),
        .cmd_pc   (cmd_pc),
        .cmd_len  (cmd_len),
        .owner_q  (owner_q),
        .start_q  (start_q),
        .end_q    (end_q)
    );

    rptc_match #(.TW(TW), .PCW(PCW)) u_match (
        .exec_valid (exec_valid),
        .exec_task  (exec_task),
        .exec_pc    (exec_pc),
        .owner_q    (owner_q),
        .end_q      (end_q),
        .end_hit    (end_hit)
    );

    rptc_passes #(.CW(CW)) u_passes (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .dec       (dec),
        .cmd_count (cmd_count),
        .multi_cmd (multi_cmd),
        .two_left  (two_left)
    );

    // Next-state decision: cancel, then command, then end-of-block hit.
    always_comb begin
        st_nxt = st;
        load   = 1'b0;
        dec    = 1'b0;
        if (cancel) begin
            st_nxt = ST_IDLE;                            // drop
        end else if (cmd_valid) begin
            load   = 1'b1;
            st_nxt = multi_cmd ? ST_RUN : ST_FINAL;      // arm-run / arm-final
        end else if (end_hit) begin
            unique case (st)
                ST_RUN: begin
                    dec    = 1'b1;
                    st_nxt = two_left ? ST_FINAL : ST_RUN; // to-last / loop
                end
                ST_FINAL: st_nxt = ST_IDLE;              // retire
                default:  st_nxt = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // Outputs.
    always_comb begin
        jump_req    = 1'b0;
        jump_target = start_q;
        active      = 1'b0;
        unique case (st)
            ST_IDLE: begin
                jump_req = 1'b0;
                active   = 1'b0;
            end
            ST_RUN: begin
                jump_req = end_hit && !cancel && !cmd_valid;
                active   = !cancel;
            end
            ST_FINAL: begin
                jump_req = 1'b0;
                active   = !cancel;
            end
            default: begin
                jump_req = 1'b0;
                active   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rptc_checker.sv
module rptc_checker #(
    parameter int TW  = 2,
    parameter int PCW = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cmd_valid,
    input logic                  cancel,
    input logic                  exec_valid,
    input logic [TW-1:0]         exec_task,
    input logic [PCW-1:0]        exec_pc,
    input logic                  jump_req,
    input logic                  active,
    input logic [TW-1:0]         owner_q,
    input logic [PCW-1:0]        end_q,
    input rptc_pkg::rpt_state_e  st
);
    import rptc_pkg::*;

    // R1: jumps only for the owner at the block end
    assert_owner_only_R1: assert property (@(posedge clk) disable iff (rst)
        jump_req |-> (exec_task == owner_q && exec_pc == end_q));

    // R3: the last pass never jumps
    assert_final_no_jump_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FINAL) |-> !jump_req);

    // R4: an accepted command arms the controller
    assert_cmd_arms_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cancel) |=> (st != ST_IDLE));

    // R6: cancel leaves nothing active on the next cycle
    assert_cancel_clears_R6: assert property (@(posedge clk) disable iff (rst)
        cancel |=> (st == ST_IDLE));

    // R7: reset returns to idle
    assert_reset_idle_R7: assert property (@(posedge clk)
        rst |=> (st == ST_IDLE));

    // R8: no executed instruction, no jump
    assert_invalid_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !exec_valid |-> !jump_req);

    // R10: no jump without an active repeat
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !active |-> !jump_req);
endmodule

bind task_rpt_ctrl rptc_checker #(.TW(TW), .PCW(PCW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cancel     (cancel),
    .exec_valid (exec_valid),
    .exec_task  (exec_task),
    .exec_pc    (exec_pc),
    .jump_req   (jump_req),
    .active     (active),
    .owner_q    (owner_q),
    .end_q      (end_q),
    .st         (st)
);

// File: tb/sim_task_rpt_ctrl.sv
`timescale 1ns/1ps
module sim_task_rpt_ctrl;
    localparam int TASKS = 4;
    localparam int PCW   = 8;
    localparam int CW    = 8;
    localparam int TW    = 2;

    logic           clk = 1'b0;
    logic           rst;
    logic           cmd_valid;
    logic [TW-1:0]  cmd_task;
    logic [PCW-1:0] cmd_pc;
    logic [PCW-1:0] cmd_len;
    logic [CW-1:0]  cmd_count;
    logic           cancel;
    logic           exec_valid;
    logic [TW-1:0]  exec_task;
    logic [PCW-1:0] exec_pc;
    logic           jump_req;
    logic [PCW-1:0] jump_target;
    logic           active;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    task_rpt_ctrl #(.TASKS(TASKS), .PCW(PCW), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_task(cmd_task),
        .cmd_pc(cmd_pc), .cmd_len(cmd_len), .cmd_count(cmd_count),
        .cancel(cancel), .exec_valid(exec_valid), .exec_task(exec_task),
        .exec_pc(exec_pc), .jump_req(jump_req), .jump_target(jump_target),
        .active(active)
    );

    // Row: {req(4), cv, ct(2), cpc(8), clen(8), ccnt(8), cancel,
    //       xv, xt(2), xpc(8), exp_jump, exp_tgt(8), exp_act}
    localparam int NV = 27;
    localparam logic [52:0] VEC [NV] = '{
        {4'd2,  1'b1,2'd1,8'd10, 8'd3,8'd3, 1'b0, 1'b0,2'd0,8'd0,   1'b0,8'd0,  1'b0}, // R2 arm
        {4'd10, 1'b0,2'd0,8'd0,  8'd0,8'd0, 1'b0, 1'b1,2'd1,8'd11,  1'b0,8'd0,  1'b1}, // R10
        {4'd1,  1'b0,2'd0,8'd0,  8'd0,8'd0, 1'b0, 1'b1,2'd2,8'd13,  1'b0,8'd0,  1'b1}, // R1 other task
        {4'd2,  1'b0,2'd0,8'd0,  8'd0,8'd0, 1'b0, 1'b1,2'd1,8'd13,  1'b1,8'd11, 1'b1}, // R2 jump 1
        {4'd2,  1'b0,2'd0,8'd0,  8'd0,8'd0, 1'b0, 1'b1,2'd1,8'd13,  1'b1,8'd11, 1'b1}, // R2 jump 2
        {4'd2,  1'b0,2'd0,8'd0,  8'd0,8'd0, 1'b0, 1'b1,2'd1,8'd13,  1'b0,8'd0,  1'b1}, // R2 last pass
        {4'd10, 1'b0,2'd0,8'd0,  8'd0,8'd0, 1'b0, 1'b1,2'd1,8'd13,  1'b0,8'd0,  1'b0}, // R10 retired
        {4'd3,  1'b1,2'd3,8'd40, 8'd0,8'd0, 1'b0, 1'b0,2'd0,8'd0,   1'b0,8'd0,  1'b0}, // R3 zero len/count
        {4'd3,  1'b0,2'd0,8'd0,  8'd0,8'd0, 1'b0, 1'b1,2'd3,8'd41,  1'b0,8'd0,  1'b1}, // R3 no jump
        {4'd3,  1'b0,2'd0,8'd0,  8'd0,8'd0, 1'b0, 1'b1,2'd3,8'd41,  1'b0,8'd0,  1'b0}, // R3 retired
        {4'd2,  1'b1,2'd0,8'd100,8'd1,8'd5, 1'b0, 1'b0,2'd0,8'd0,   1'b0,8'd0,  1'b0}, // R2 arm len 1
        {4'd2,  1'b0,2'd0,8'd0,  8'd0,8'd0, 1'b0, 1'b1,2'd0,8'd101, 1'b1,8'd101,1'b1}, // R2
        {4'd4,  1'b1,2'd2,8'd200,8'd2,8'd2, 1'b0, 1'b1,2'd0,8'd101, 1'b0,8'd0,  1'b1}, // R4 cmd blocks jump
        {4'd4,  1'b0,2'd0,8'd0,  8'd0,8'd0, 1'b0, 1'b1,2'd0,8'd101, 1'b0,8'd0,  1'b1}, // R4 old owner ignored
        {4'd4,  1'b0,2'd0,8'd0,  8'd0,8'd0, 1'b0, 1'b1,2'd2,8'd202, 1'b1,8'd201,1'b1}, // R4 new owner
        {4'd6,  1'b0,2'd0,8'd0,  8'd0,8'd0, 1'b1, 1'b1,2'd2,8'd202, 1'b0,8'd0,  1'b0}, // R6 cancel
        {4'd6,  1'b0,2'd0,8'd0,  8'd0,8'd0, 1'b0, 1'b1,2'd2,8'd202, 1'b0,8'd0,  1'b0}, // R6 cleared
        {4'd5,  1'b1,2'd1,8'd50, 8'd2,8'd2, 1'b0, 1'b0,2'd0,8'd0,   1'b0,8'd0,  1'b0}, // R5 arm
        {4'd5,  1'b0,2'd0,8'd0,  8'd0,8'd0, 1'b0, 1'b1,2'd1,8'd90,  1'b0,8'd0,  1'b1}, // R5 redirect
        {4'd5,  1'b0,2'd0,8'd0,  8'd0,8'd0, 1'b0, 1'b1,2'd1,8'd52,  1'b1,8'd51, 1'b1}, // R5 still loops
        {4'd8,  1'b0,2'd0,8'd0,  8'd0,8'd0, 1'b0, 1'b0,2'd1,8'd52,  1'b0,8'd0,  1'b1}, // R8 invalid
        {4'd8,  1'b0,2'd0,8'd0,  8'd0,8'd0, 1'b0, 1'b1,2'd1,8'd52,  1'b0,8'd0,  1'b1}, // R8 pass kept
        {4'd10, 1'b0,2'd0,8'd0,  8'd0,8'd0, 1'b0, 1'b0,2'd0,8'd0,   1'b0,8'd0,  1'b0}, // R10
        {4'd6,  1'b1,2'd0,8'd5,  8'd1,8'd3, 1'b1, 1'b0,2'd0,8'd0,   1'b0,8'd0,  1'b0}, // R6 beats cmd
        {4'd6,  1'b0,2'd0,8'd0,  8'd0,8'd0, 1'b0, 1'b1,2'd0,8'd6,   1'b0,8'd0,  1'b0}, // R6 not armed
        {4'd9,  1'b1,2'd0,8'd254,8'd3,8'd2, 1'b0, 1'b0,2'd0,8'd0,   1'b0,8'd0,  1'b0}, // R9 wrap arm
        {4'd9,  1'b0,2'd0,8'd0,  8'd0,8'd0, 1'b0, 1'b1,2'd0,8'd1,   1'b1,8'd255,1'b1}  // R9 wrapped end
    };

    task automatic drive(input logic cv, input logic [1:0] ct, input logic [7:0] cpc,
                         input logic [7:0] clen, input logic [7:0] ccnt, input logic can,
                         input logic xv, input logic [1:0] xt, input logic [7:0] xpc);
        cmd_valid = cv; cmd_task = ct; cmd_pc = cpc; cmd_len = clen; cmd_count = ccnt;
        cancel = can; exec_valid = xv; exec_task = xt; exec_pc = xpc;
    endtask

    task automatic idle();
        drive(1'b0, 2'd0, 8'd0, 8'd0, 8'd0, 1'b0, 1'b0, 2'd0, 8'd0);
    endtask

    task automatic chk(input int req, input logic ej, input logic [7:0] et, input logic ea);
        checks++;
        if (jump_req !== ej || active !== ea || (ej && jump_target !== et)) begin
            errors++;
            $display("FAIL R%0d: jump=%0b tgt=%0d act=%0b expected jump=%0b tgt=%0d act=%0b",
                     req, jump_req, jump_target, active, ej, et, ea);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1 chk(7, 1'b0, 8'd0, 1'b0);   // R7 reset state

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][48], VEC[i][47:46], VEC[i][45:38], VEC[i][37:30], VEC[i][29:22],
                  VEC[i][21], VEC[i][20], VEC[i][19:18], VEC[i][17:10]);
            #1 chk(int'(VEC[i][52:49]), VEC[i][9], VEC[i][8:1], VEC[i][0]);
        end

        // R7: reset in the middle of a loop
        @(negedge clk); drive(1'b1, 2'd2, 8'd20, 8'd2, 8'd4, 1'b0, 1'b0, 2'd0, 8'd0);
        @(negedge clk); idle(); rst = 1'b1;
        #1 chk(7, 1'b0, 8'd0, 1'b1);
        @(negedge clk); rst = 1'b0; drive(1'b0, 2'd0, 8'd0, 8'd0, 8'd0, 1'b0, 1'b1, 2'd2, 8'd22);
        #1 chk(7, 1'b0, 8'd0, 1'b0);

        // R3: count 0 with a longer block is a single pass
        @(negedge clk); drive(1'b1, 2'd0, 8'd60, 8'd3, 8'd0, 1'b0, 1'b0, 2'd0, 8'd0);
        @(negedge clk); drive(1'b0, 2'd0, 8'd0, 8'd0, 8'd0, 1'b0, 1'b1, 2'd0, 8'd63);
        #1 chk(3, 1'b0, 8'd0, 1'b1);
        @(negedge clk); idle();
        #1 chk(3, 1'b0, 8'd0, 1'b0);

        // R2: count 2 gives exactly one jump
        @(negedge clk); drive(1'b1, 2'd3, 8'd70, 8'd4, 8'd2, 1'b0, 1'b0, 2'd0, 8'd0);
        @(negedge clk); drive(1'b0, 2'd0, 8'd0, 8'd0, 8'd0, 1'b0, 1'b1, 2'd3, 8'd74);
        #1 chk(2, 1'b1, 8'd71, 1'b1);
        @(negedge clk);
        #1 chk(2, 1'b0, 8'd0, 1'b1);
        @(negedge clk); idle();
        #1 chk(10, 1'b0, 8'd0, 1'b0);

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule